// File: doc/BRIEF.md
# Burst-Mode Conversion Sequencer

This block is the digital controller for a 12-bit successive-approximation converter. One of four trigger sources is selected by a 2-bit code. In single mode, when the converter enable is set, every accepted trigger runs one conversion. The result is placed in the accumulator output.

In burst mode, one trigger does the whole job with no processor action. It powers the converter up and waits a programmable settling time if the converter was off. It then runs 1, 4, 8 or 16 conversions and adds their results into a 16-bit accumulator. At the end it drops power again.

The sequencer drives three signals to an abstract converter model: a power-enable level, a track level and a one-cycle start strobe. The model answers each start strobe with a done pulse and a 12-bit sample. The whole block runs on the clock `clk`, which is the dedicated sequencing clock (at most 25 MHz), not the system clock.

Top module: `adc_burst_seq`

## Requirements
- R1: `trig_sel_i` picks the accepted trigger: 0 = `sw_start_i`, 1 = `tmr1_ovf_i`, 2 = `cnv_pin_i`, 3 = `tmr2_ovf_i`. Pulses on the three unselected inputs have no effect. Every trigger input is a one-cycle pulse.
- R2: With `burst_en_i`=0 and `enable_i`=1, an accepted trigger runs exactly one conversion. Afterwards `acc_o` equals that sample.
- R3: With `burst_en_i`=0 and `enable_i`=0, triggers are ignored. `busy_o` stays low and `acc_o` keeps its value.
- R4: In burst mode, `rpt_sel_i` sets the number of conversions per trigger: 0 = 1, 1 = 4, 2 = 8, 3 = 16. The accumulator is cleared when the trigger is accepted. At the end, `acc_o` holds the sum of the samples.
- R5: A burst started with `enable_i`=0 first waits (`pwr_time_i`+1)*8 cycles with power on and track low. A burst started with `enable_i`=1 skips this wait.
- R6: `adc_pwr_o` is high whenever `enable_i` is 1 or a sequence is busy. It is low otherwise, including straight after a burst that ran with `enable_i`=0.
- R7: `busy_o` rises at the edge that accepts the trigger. It falls at the edge where the last done pulse is taken. It is high for W + N*(TRACK_CYC+1+L) cycles, where W is the R5 wait, N the conversion count and L the converter latency in cycles.
- R8: Each conversion holds `track_o` high for TRACK_CYC cycles (default 2). Then `conv_start_o` is high for one cycle. Then the sequencer waits for `conv_done_i`.
- R9: `irq_o` is set at the edge where the last result is taken and stays set until `irq_clr_i`. If a set and a clear fall on the same edge, the set wins.
- R10: A trigger that arrives while `busy_o` is high is ignored. The number of conversions and the busy length do not change.
- R11: Sixteen full-scale samples (4095) sum to 65520 in `acc_o` without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable bit |
| burst_en_i | input | 1 | Burst mode select |
| trig_sel_i | input | 2 | Trigger source select |
| sw_start_i | input | 1 | Software start pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| cnv_pin_i | input | 1 | External convert-start pulse |
| tmr2_ovf_i | input | 1 | Timer 2 overflow pulse |
| rpt_sel_i | input | 2 | Conversions per burst code |
| pwr_time_i | input | 4 | Power-up wait code |
| irq_clr_i | input | 1 | Interrupt flag clear |
| conv_done_i | input | 1 | Converter result valid pulse |
| conv_data_i | input | 12 | Converter sample |
| adc_pwr_o | output | 1 | Converter power enable |
| track_o | output | 1 | Track phase |
| conv_start_o | output | 1 | Start-conversion strobe |
| busy_o | output | 1 | Sequence in progress |
| irq_o | output | 1 | Sticky completion flag |
| acc_o | output | 16 | Accumulated result |

## Verification
The completion flag can be set and cleared in the same cycle. The bench takes the busy length known from R7 and pulses `irq_clr_i` exactly on the edge where the last done pulse is taken. It then expects `irq_o` to read 1, because the set must win. A second overlap is a retrigger that lands in the middle of a burst. It is judged by comparing the start-strobe count and the busy length with the values of an undisturbed burst.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WARM  = 3'd1,
    ST_TRACK = 3'd2,
    ST_START = 3'd3,
    ST_CONV  = 3'd4
  } seq_state_t;

  // Conversions per burst for each repeat code.
  function automatic logic [4:0] rpt_count(input logic [1:0] code);
    case (code)
      2'd0:    rpt_count = 5'd1;
      2'd1:    rpt_count = 5'd4;
      2'd2:    rpt_count = 5'd8;
      default: rpt_count = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             trig_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src_i[g] && (sel_i == SEL_W'(g));
  end

  assign trig_o = |hit;
endmodule

// File: rtl/adc_accum.sv
module adc_accum #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = clr_i || add_i;
    acc_d  = clr_i ? '0 : acc_q + ACC_W'(data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int PWR_W     = 4,
  parameter int WARM_UNIT = 8,
  parameter int TRACK_CYC = 2,
  localparam int WARM_MAX = (1 << PWR_W) * WARM_UNIT,
  localparam int CNT_W    = $clog2(WARM_MAX + TRACK_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             enable_i,
  input  logic             burst_i,
  input  logic [1:0]       rpt_i,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic             done_i,
  input  logic             irq_clr_i,
  output logic             busy_o,
  output logic             track_o,
  output logic             start_o,
  output logic             acc_clr_o,
  output logic             acc_add_o,
  output logic             irq_o
);
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [4:0]       rem_q, rem_d;
  logic             irq_q, irq_d;
  logic             fin;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    rem_d     = rem_q;
    acc_clr_o = 1'b0;
    acc_add_o = 1'b0;
    fin       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_i && (burst_i || enable_i)) begin
          acc_clr_o = 1'b1;
          rem_d     = burst_i ? rpt_count(rpt_i) - 5'd1 : 5'd0;
          if (burst_i && !enable_i) begin
            state_d = ST_WARM;
            cnt_d   = CNT_W'((32'(pwr_i) + 1) * WARM_UNIT - 1);
          end else begin
            state_d = ST_TRACK;
            cnt_d   = CNT_W'(TRACK_CYC - 1);
          end
        end
      end
      ST_WARM: begin
        if (cnt_q == '0) begin
          state_d = ST_TRACK;
          cnt_d   = CNT_W'(TRACK_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TRACK: begin
        if (cnt_q == '0) state_d = ST_START;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_START: state_d = ST_CONV;
      ST_CONV: begin
        if (done_i) begin
          acc_add_o = 1'b1;
          if (rem_q == '0) begin
            state_d = ST_IDLE;
            fin     = 1'b1;
          end else begin
            rem_d   = rem_q - 5'd1;
            state_d = ST_TRACK;
            cnt_d   = CNT_W'(TRACK_CYC - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    irq_d = fin ? 1'b1 : (irq_clr_i ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      irq_q   <= irq_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign track_o = (state_q == ST_TRACK);
  assign start_o = (state_q == ST_START);
  assign irq_o   = irq_q;
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq #(
  parameter int DATA_W    = 12,
  parameter int ACC_W     = 16,
  parameter int PWR_W     = 4,
  parameter int WARM_UNIT = 8,
  parameter int TRACK_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              burst_en_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              sw_start_i,
  input  logic              tmr1_ovf_i,
  input  logic              cnv_pin_i,
  input  logic              tmr2_ovf_i,
  input  logic [1:0]        rpt_sel_i,
  input  logic [PWR_W-1:0]  pwr_time_i,
  input  logic              irq_clr_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              adc_pwr_o,
  output logic              track_o,
  output logic              conv_start_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       trig;
  logic       acc_clr, acc_add;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_trig_sel #(.N_SRC(4)) u_trig (
    .src_i  ({tmr2_ovf_i, cnv_pin_i, tmr1_ovf_i, sw_start_i}),
    .sel_i  (trig_sel_i),
    .trig_o (trig)
  );

  adc_seq_fsm #(
    .PWR_W(PWR_W), .WARM_UNIT(WARM_UNIT), .TRACK_CYC(TRACK_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trig_i    (trig),
    .enable_i  (enable_i),
    .burst_i   (burst_en_i),
    .rpt_i     (rpt_sel_i),
    .pwr_i     (pwr_time_i),
    .done_i    (conv_done_i),
    .irq_clr_i (irq_clr_i),
    .busy_o    (busy_o),
    .track_o   (track_o),
    .start_o   (conv_start_o),
    .acc_clr_o (acc_clr),
    .acc_add_o (acc_add),
    .irq_o     (irq_o)
  );

  adc_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (acc_clr),
    .add_i  (acc_add),
    .data_i (conv_data_i),
    .acc_o  (acc_o)
  );

  assign adc_pwr_o = enable_i || busy_o;
endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable_i,
  input logic burst_en_i,
  input logic irq_clr_i,
  input logic adc_pwr_o,
  input logic track_o,
  input logic conv_start_o,
  input logic busy_o,
  input logic irq_o
);
  // R6
  pwr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> adc_pwr_o);

  // R8
  track_start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(track_o && conv_start_o));

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  // R8
  start_after_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> $past(track_o));

  // R9
  irq_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> irq_o);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R3
  idle_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !burst_en_i && !enable_i) |=> !busy_o);
endmodule

bind adc_burst_seq adc_burst_seq_chk u_chk (.*);

// File: tb/adc_burst_seq_tb.sv
module adc_burst_seq_tb;
  localparam int T_TRK = 2;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable_i, burst_en_i, sw_start_i, tmr1_ovf_i, cnv_pin_i, tmr2_ovf_i;
  logic [1:0]  trig_sel_i, rpt_sel_i;
  logic [3:0]  pwr_time_i;
  logic        irq_clr_i, conv_done_i;
  logic [11:0] conv_data_i;
  logic        adc_pwr_o, track_o, conv_start_o, busy_o, irq_o;
  logic [15:0] acc_o;

  int checks = 0;
  int errors = 0;
  int m_pend = 0;
  int m_idx  = 0;
  int g_base = 0;
  int g_step = 0;

  always #10 clk = ~clk;

  adc_burst_seq u_dut (.*);

  // Converter model: done pulse LAT negedges after a start strobe.
  always @(negedge clk) begin
    conv_done_i = 1'b0;
    if (m_pend > 0) begin
      m_pend = m_pend - 1;
      if (m_pend == 0) begin
        conv_done_i = 1'b1;
        conv_data_i = 12'((g_base + m_idx * g_step) % 4096);
        m_idx = m_idx + 1;
      end
    end
    if (conv_start_o) m_pend = LAT;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] src);
    @(negedge clk);
    case (src)
      2'd0: sw_start_i = 1'b1;
      2'd1: tmr1_ovf_i = 1'b1;
      2'd2: cnv_pin_i  = 1'b1;
      default: tmr2_ovf_i = 1'b1;
    endcase
    @(negedge clk);
    {sw_start_i, tmr1_ovf_i, cnv_pin_i, tmr2_ovf_i} = 4'b0;
  endtask

  int busy_n, track_n, start_n, pwr_n;

  task automatic run(input logic [1:0] src, input int retrig_at, input int clr_at);
    int guard;
    busy_n = 0; track_n = 0; start_n = 0; pwr_n = 0; guard = 0;
    m_idx = 0;
    fire(src);
    while (1) begin
      sw_start_i = 1'b0;
      irq_clr_i  = 1'b0;
      if (!busy_o || guard > 5000) break;
      busy_n++;
      track_n += int'(track_o);
      start_n += int'(conv_start_o);
      pwr_n   += int'(adc_pwr_o);
      if (busy_n == retrig_at) sw_start_i = 1'b1;
      if (busy_n == clr_at)    irq_clr_i  = 1'b1;
      guard++;
      @(negedge clk);
    end
  endtask

  function automatic int nconv(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  // {burst, enable, sel, rpt, pwr, base, step}
  localparam logic [33:0] VEC [0:5] = '{
    {1'b0, 1'b1, 2'd0, 2'd3, 4'd0,  12'd100,  12'd0},
    {1'b0, 1'b1, 2'd2, 2'd0, 4'd0,  12'd4095, 12'd0},
    {1'b1, 1'b0, 2'd1, 2'd1, 4'd0,  12'd10,   12'd5},
    {1'b1, 1'b0, 2'd3, 2'd2, 4'd15, 12'd1000, 12'd300},
    {1'b1, 1'b1, 2'd0, 2'd0, 4'd5,  12'd77,   12'd0},
    {1'b1, 1'b0, 2'd2, 2'd3, 4'd2,  12'd4095, 12'd0}
  };

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {enable_i, burst_en_i, sw_start_i, tmr1_ovf_i, cnv_pin_i, tmr2_ovf_i} = '0;
    trig_sel_i = 2'd0; rpt_sel_i = 2'd0; pwr_time_i = 4'd0;
    irq_clr_i = 1'b0; conv_done_i = 1'b0; conv_data_i = '0;
    repeat (3) @(negedge clk);
    check("reset busy R7", int'(busy_o), 0);
    check("reset irq R9", int'(irq_o), 0);
    check("reset acc R4", int'(acc_o), 0);
    check("reset pwr R6", int'(adc_pwr_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      automatic logic [33:0] v = VEC[i];
      automatic int n   = v[33] ? nconv(v[29:28]) : 1;
      automatic int w   = (v[33] && !v[32]) ? (int'(v[27:24]) + 1) * 8 : 0;
      automatic int sum = 0;
      burst_en_i = v[33]; enable_i = v[32]; trig_sel_i = v[31:30];
      rpt_sel_i = v[29:28]; pwr_time_i = v[27:24];
      g_base = int'(v[23:12]); g_step = int'(v[11:0]);
      for (int j = 0; j < n; j++) sum += (g_base + j * g_step) % 4096;
      run(v[31:30], -1, -1);
      check("acc R2 R4 R11", int'(acc_o), sum);
      check("busy length R7 R5", busy_n, w + n * (T_TRK + 1 + LAT));
      check("start count R8 R1", start_n, n);
      check("track count R8 R5", track_n, n * T_TRK);
      check("pwr while busy R6", pwr_n, busy_n);
      check("pwr after R6", int'(adc_pwr_o), int'(v[32]));
      check("irq set R9", int'(irq_o), 1);
      @(negedge clk); irq_clr_i = 1'b1;
      @(negedge clk); irq_clr_i = 1'b0;
      check("irq clear R9", int'(irq_o), 0);
    end
    // Last vector: 16 x 4095 = 65520, acc stays there below.

    // R3: single mode, enable low -> ignored
    burst_en_i = 1'b0; enable_i = 1'b0; trig_sel_i = 2'd0;
    fire(2'd0);
    repeat (3) @(negedge clk);
    check("disabled busy R3", int'(busy_o), 0);
    check("disabled acc R3", int'(acc_o), 65520);
    check("disabled pwr R3 R6", int'(adc_pwr_o), 0);

    // R1: unselected source ignored
    enable_i = 1'b1; trig_sel_i = 2'd1;
    fire(2'd3);
    fire(2'd0);
    fire(2'd2);
    repeat (2) @(negedge clk);
    check("unselected busy R1", int'(busy_o), 0);
    check("unselected acc R1", int'(acc_o), 65520);

    // R10: retrigger mid-burst ignored
    burst_en_i = 1'b1; enable_i = 1'b0; trig_sel_i = 2'd0;
    rpt_sel_i = 2'd1; pwr_time_i = 4'd0; g_base = 1; g_step = 1;
    run(2'd0, 12, -1);
    check("retrig busy R10", busy_n, 8 + 4 * (T_TRK + 1 + LAT));
    check("retrig starts R10", start_n, 4);
    check("retrig acc R10", int'(acc_o), 10);
    repeat (3) @(negedge clk);
    check("retrig idle R10", int'(busy_o), 0);
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    check("pre clear R9", int'(irq_o), 0);

    // R9: clear on the same edge as the final set
    rpt_sel_i = 2'd0;
    run(2'd0, -1, 8 + 1 * (T_TRK + 1 + LAT));
    check("set beats clear R9", int'(irq_o), 1);
    check("set beats clear acc R2", int'(acc_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule